// File: doc/BRIEF.md
# Three-TAP JTAG Chain with One-Way Disables

This block is one device that shows three test access ports on a single JTAG chain. Each port has a 4-bit instruction register, a 1-bit bypass register and a 32-bit identification register. All three share TCK, TMS and the optional TRST. Data flows from TDI into the first coprocessor port, then into the second coprocessor port, then into the main core port, and out on TDO. The main core port is therefore the device nearest TDO.

A control register sits on a simple bus port and holds one disable bit per port. Software can set a disable bit but cannot clear it. Only a chip reset clears it. A disabled port is cut out of the chain, not placed in bypass. Its instruction bits and data bits both drop out of the path, so the total instruction length goes from 12 to 8, then 4, then 0.

A change to the disable bits reaches the chain only while the controllers sit in Test-Logic-Reset or Run-Test/Idle. A scan that is under way therefore keeps its length. When all three ports are removed, TDI reaches TDO through one flop clocked on the falling edge of TCK.

Top module: `multi_tap_chain`

## Requirements
- R1: After chip reset (rst_n low) the control register reads 0x00000000 and all three ports are in the chain, so an instruction scan of 16 ones returns 0xF111 (LSB first).
- R2: In Capture-IR every port in the chain loads 4'b0001, and the main core port's bits leave TDO first. With all ports present, the first 12 bits out are 0x111 and later bits are TDI delayed by 12.
- R3: TRST low, or five TCK cycles with TMS high, puts every port in Test-Logic-Reset. Every port then selects IDCODE (instruction 4'h1). A data scan then returns 0x4BA00477 (main core) first, followed by 0x0BA01477 for each coprocessor port.
- R4: Any instruction other than 4'h1, such as 4'hF, selects a 1-bit bypass that captures 0. With all three ports in bypass the data path is 3 bits long.
- R5: Each port chooses its own data register. Instruction bits shifted in first land in the main core port. An instruction scan of 0x1F1 gives a data path of 32+1+32 bits.
- R6: Control bit 10 removes the first coprocessor port (furthest from TDO). Bit 12 removes the second coprocessor port. Bit 11 removes the main core port. A removed port adds no instruction bits and no data bits.
- R7: Once written to 1, bits 10, 11 and 12 stay 1. Writes of 0 to them are ignored, and only rst_n clears them.
- R8: All other control bits are plain storage that a single-cycle write sets or clears and a read returns.
- R9: A change to the disable bits takes effect only while the controllers are in Test-Logic-Reset or Run-Test/Idle. A disable written during Shift-DR does not change the scan in progress.
- R10: With all three ports removed, TDO equals the TDI value sampled at the previous TCK falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Chip reset, active low, clears the control register |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 32 | Control register write data |
| reg_rdata | output | 32 | Control register read data |
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, asynchronous |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| tdo | output | 1 | Test data out, updated on the TCK falling edge |

## Verification
Three kinds of scan are run with the chain at 12, 8, 4 and 0 instruction bits, and each kind separates a different fault.
- Instruction scans of all ones show the captured 0001 groups, and the delay before TDI reappears gives the chain length.
- Data scans after a reset separate the order of the identification codes and their values.
- Scans after a mixed or all-bypass instruction load separate how each port picks its own register.

Disable writes are also made at three other points: a zero write to an already set bit, a write in the middle of Shift-DR, and the write that removes the last port. These separate sticky storage from plain storage, deferred splicing from immediate splicing, and a removed port from a bypassed one.

// File: rtl/multi_tap_chain.sv
module multi_tap_chain #(
  parameter int NTAP = 3,
  parameter int IRW = 4,
  parameter int IDW = 32,
  parameter int DW = 32,
  parameter logic [NTAP*IDW-1:0] IDCODES = {32'h0BA01477, 32'h0BA01477, 32'h4BA00477},
  parameter int DIS_POS [NTAP] = '{11, 12, 10}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          tck,
  input  logic          trst_n,
  input  logic          tms,
  input  logic          tdi,
  output logic          tdo
);
  localparam logic [IRW-1:0] IR_ID = {{(IRW-1){1'b0}}, 1'b1};

  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SELDR, S_CAPDR, S_SHDR, S_EX1DR, S_PAUDR, S_EX2DR, S_UPDDR,
    S_SELIR, S_CAPIR, S_SHIR, S_EX1IR, S_PAUIR, S_EX2IR, S_UPDIR
  } tap_st_t;

  function automatic logic [DW-1:0] sticky_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int k = 0; k < NTAP; k++) m[DIS_POS[k]] = 1'b1;
    return m;
  endfunction
  localparam logic [DW-1:0] STICKY = sticky_mask();

  logic [DW-1:0] ctrl_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl_q <= '0;
    else if (reg_we) ctrl_q <= (reg_wdata & ~STICKY) | ((reg_wdata | ctrl_q) & STICKY);
  assign reg_rdata = ctrl_q;

  tap_st_t state, state_nx;
  always_comb begin
    case (state)
      S_TLR:   state_nx = tms ? S_TLR   : S_RTI;
      S_RTI:   state_nx = tms ? S_SELDR : S_RTI;
      S_SELDR: state_nx = tms ? S_SELIR : S_CAPDR;
      S_CAPDR: state_nx = tms ? S_EX1DR : S_SHDR;
      S_SHDR:  state_nx = tms ? S_EX1DR : S_SHDR;
      S_EX1DR: state_nx = tms ? S_UPDDR : S_PAUDR;
      S_PAUDR: state_nx = tms ? S_EX2DR : S_PAUDR;
      S_EX2DR: state_nx = tms ? S_UPDDR : S_SHDR;
      S_UPDDR: state_nx = tms ? S_SELDR : S_RTI;
      S_SELIR: state_nx = tms ? S_TLR   : S_CAPIR;
      S_CAPIR: state_nx = tms ? S_EX1IR : S_SHIR;
      S_SHIR:  state_nx = tms ? S_EX1IR : S_SHIR;
      S_EX1IR: state_nx = tms ? S_UPDIR : S_PAUIR;
      S_PAUIR: state_nx = tms ? S_EX2IR : S_PAUIR;
      S_EX2IR: state_nx = tms ? S_UPDIR : S_SHIR;
      default: state_nx = tms ? S_SELDR : S_RTI;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) state <= S_TLR;
    else state <= state_nx;

  wire idle_st = (state == S_TLR) || (state == S_RTI);
  wire ir_path = (state == S_CAPIR) || (state == S_SHIR) || (state == S_EX1IR) ||
                 (state == S_PAUIR) || (state == S_EX2IR) || (state == S_UPDIR);

  logic [NTAP-1:0] dis_now, dis_s1, dis_s2, active;
  logic [NTAP:0]   link;
  assign link[NTAP] = tdi;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) begin
      dis_s1 <= '0;
      dis_s2 <= '0;
      active <= '1;
    end else begin
      dis_s1 <= dis_now;
      dis_s2 <= dis_s1;
      if (idle_st) active <= ~dis_s2;
    end

  a_r9_defer: assert property (@(posedge tck) disable iff (!trst_n)
    (active != $past(active)) |-> ($past(state) == S_TLR || $past(state) == S_RTI));

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    logic [IRW-1:0] ir_r, irs_r;
    logic [IDW-1:0] drs_r;
    wire sel_id = (ir_r == IR_ID);
    wire sin = link[k+1];

    assign dis_now[k] = ctrl_q[DIS_POS[k]];
    assign link[k] = active[k] ? (ir_path ? irs_r[0] : drs_r[0]) : sin;

    always_ff @(posedge tck or negedge trst_n)
      if (!trst_n) begin
        ir_r  <= IR_ID;
        irs_r <= '0;
        drs_r <= '0;
      end else if (state == S_TLR) begin
        ir_r <= IR_ID;
      end else if (active[k]) begin
        case (state)
          S_CAPIR: irs_r <= IR_ID;
          S_SHIR:  irs_r <= {sin, irs_r[IRW-1:1]};
          S_UPDIR: ir_r  <= irs_r;
          S_CAPDR: drs_r <= sel_id ? IDCODES[k*IDW +: IDW] : '0;
          S_SHDR:  if (sel_id) drs_r <= {sin, drs_r[IDW-1:1]};
                   else drs_r[0] <= sin;
          default: ;
        endcase
      end

    a_r2_capture: assert property (@(posedge tck) disable iff (!trst_n)
      (state == S_CAPIR && active[k]) |=> (irs_r == 4'b0001));
    a_r3_tlr_idcode: assert property (@(posedge tck) disable iff (!trst_n)
      (state == S_TLR) |=> (ir_r == IR_ID));
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[DIS_POS[k]] |=> ctrl_q[DIS_POS[k]]);
  end

  logic tdo_q;
  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n) tdo_q <= 1'b0;
    else tdo_q <= link[0];
  assign tdo = tdo_q;

  a_r10_passthru: assert property (@(negedge tck) disable iff (!trst_n)
    (active == '0) |=> (tdo == $past(tdi)));
endmodule

// File: tb/multi_tap_chain_bench.sv
module multi_tap_chain_bench;
  localparam logic [31:0] MAIN_ID = 32'h4BA00477;
  localparam logic [31:0] COP_ID  = 32'h0BA01477;

  logic clk = 0, rst_n = 0, reg_we = 0, tck = 0, trst_n = 0, tms = 0, tdi = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic tdo;

  multi_tap_chain u_multi_tap_chain (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo));

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  string cur_req = "R1";

  int st;
  bit q[$];
  int irv[3];
  bit act[3];
  bit pend[3];
  bit prev_tdi;
  logic last_tdo;
  logic [31:0] ids[3];
  logic [127:0] dout;

  task automatic chk(input bit ok, input string req, input logic [127:0] a, input logic [127:0] e);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  function automatic int nxt(input int s, input bit m);
    case (s)
      0: return m ? 0 : 1;
      1: return m ? 2 : 1;
      2: return m ? 9 : 3;
      3, 4: return m ? 5 : 4;
      5: return m ? 8 : 6;
      6: return m ? 7 : 6;
      7: return m ? 8 : 4;
      9: return m ? 0 : 10;
      10, 11: return m ? 12 : 11;
      12: return m ? 15 : 13;
      13: return m ? 14 : 13;
      14: return m ? 15 : 11;
      default: return m ? 2 : 1;
    endcase
  endfunction

  task automatic tcyc(input bit m, input bit d);
    int nact;
    tms = m; tdi = d;
    #10;
    last_tdo = tdo;
    nact = 0;
    for (int k = 0; k < 3; k++) nact += act[k];
    if (st == 4 || st == 11) begin
      if (nact == 0) chk(last_tdo === prev_tdi, cur_req, last_tdo, prev_tdi);
      else chk(last_tdo === q[0], cur_req, last_tdo, q[0]);
    end
    tck = 1;
    case (st)
      10: begin
        q.delete();
        for (int k = 0; k < 3; k++) if (act[k]) begin
          q.push_back(1); q.push_back(0); q.push_back(0); q.push_back(0);
        end
      end
      3: begin
        q.delete();
        for (int k = 0; k < 3; k++) if (act[k]) begin
          if (irv[k] == 1) for (int b = 0; b < 32; b++) q.push_back(ids[k][b]);
          else q.push_back(0);
        end
      end
      4, 11: if (q.size() > 0) begin void'(q.pop_front()); q.push_back(d); end
      15: begin
        int idx;
        idx = 0;
        for (int k = 0; k < 3; k++) if (act[k]) begin
          irv[k] = q[idx] + 2*q[idx+1] + 4*q[idx+2] + 8*q[idx+3];
          idx += 4;
        end
      end
      0: for (int k = 0; k < 3; k++) irv[k] = 1;
      default: ;
    endcase
    if (st == 0 || st == 1) for (int k = 0; k < 3; k++) act[k] = !pend[k];
    st = nxt(st, m);
    prev_tdi = d;
    #20 tck = 0;
    #10;
  endtask

  task automatic bus_write(input logic [31:0] w);
    @(posedge clk); #1 reg_we = 1; reg_wdata = w;
    @(posedge clk); #1 reg_we = 0;
    if (w[11]) pend[0] = 1;
    if (w[12]) pend[1] = 1;
    if (w[10]) pend[2] = 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tcyc(0, 0);
  endtask

  task automatic scan(input bit is_ir, input logic [127:0] din, input int n,
                      input int mid, input logic [31:0] mid_w);
    tcyc(1, 0);
    if (is_ir) tcyc(1, 0);
    tcyc(0, 0);
    tcyc(0, 0);
    dout = '0;
    for (int i = 0; i < n; i++) begin
      if (i == mid) bus_write(mid_w);
      tcyc(i == n-1, din[i]);
      dout[i] = last_tdo;
    end
    tcyc(1, 0);
    tcyc(0, 0);
  endtask

  task automatic tms_reset();
    for (int i = 0; i < 5; i++) tcyc(1, 0);
    idle(2);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    ids[0] = MAIN_ID; ids[1] = COP_ID; ids[2] = COP_ID;
    st = 0; prev_tdi = 0;
    for (int k = 0; k < 3; k++) begin irv[k] = 1; act[k] = 1; pend[k] = 0; end
    #50 rst_n = 1; trst_n = 1;
    #20;
    chk(reg_rdata == 0, "R1", reg_rdata, 0);
    idle(4);

    cur_req = "R2";
    scan(1, '1, 16, -1, 0);
    chk(dout[15:0] == 16'hF111, "R2", dout[15:0], 16'hF111);

    cur_req = "R4";
    scan(0, 128'hB1, 8, -1, 0);
    chk(dout[7:0] == 8'h88, "R4", dout[7:0], 8'h88);

    cur_req = "R3";
    tms_reset();
    scan(0, '0, 96, -1, 0);
    chk(dout[95:0] == {COP_ID, COP_ID, MAIN_ID}, "R3", dout[95:0], {COP_ID, COP_ID, MAIN_ID});

    cur_req = "R5";
    scan(1, 128'h1F1, 12, -1, 0);
    scan(0, '1, 72, -1, 0);
    chk(dout[71:0] == {7'h7F, COP_ID, 1'b0, MAIN_ID}, "R5", dout[71:0], {7'h7F, COP_ID, 1'b0, MAIN_ID});

    cur_req = "R3";
    trst_n = 0; #20 trst_n = 1; #10;
    st = 0;
    for (int k = 0; k < 3; k++) begin irv[k] = 1; act[k] = !pend[k]; end
    idle(3);
    scan(0, '0, 32, -1, 0);
    chk(dout[31:0] == MAIN_ID, "R3", dout[31:0], MAIN_ID);

    cur_req = "R6";
    bus_write(32'h400);
    chk(reg_rdata == 32'h400, "R6", reg_rdata, 32'h400);
    idle(4);
    scan(1, '1, 12, -1, 0);
    chk(dout[11:0] == 12'hF11, "R6", dout[11:0], 12'hF11);
    scan(0, '1, 4, -1, 0);
    chk(dout[3:0] == 4'b1100, "R6", dout[3:0], 4'b1100);

    cur_req = "R7";
    bus_write(32'h0);
    chk(reg_rdata == 32'h400, "R7", reg_rdata, 32'h400);
    idle(4);
    tms_reset();
    scan(0, '1, 68, -1, 0);
    chk(dout[67:0] == {4'hF, COP_ID, MAIN_ID}, "R7", dout[67:0], {4'hF, COP_ID, MAIN_ID});

    cur_req = "R8";
    bus_write(32'hA5A5_0003);
    chk(reg_rdata == 32'hA5A5_0403, "R8", reg_rdata, 32'hA5A5_0403);
    bus_write(32'h0);
    chk(reg_rdata == 32'h0000_0400, "R8", reg_rdata, 32'h0000_0400);

    cur_req = "R9";
    scan(0, '0, 64, 20, 32'h1400);
    chk(dout[63:0] == {COP_ID, MAIN_ID}, "R9", dout[63:0], {COP_ID, MAIN_ID});
    chk(reg_rdata == 32'h1400, "R9", reg_rdata, 32'h1400);
    idle(4);
    cur_req = "R6";
    scan(1, '1, 8, -1, 0);
    chk(dout[7:0] == 8'hF1, "R6", dout[7:0], 8'hF1);

    cur_req = "R10";
    bus_write(32'h800);
    chk(reg_rdata == 32'h1C00, "R10", reg_rdata, 32'h1C00);
    idle(4);
    scan(1, 128'hCA, 8, -1, 0);
    chk(dout[7:0] == 8'h94, "R10", dout[7:0], 8'h94);
    scan(0, 128'h35, 8, -1, 0);
    chk(dout[7:0] == 8'h6A, "R10", dout[7:0], 8'h6A);

    cur_req = "R1";
    @(posedge clk); #1 rst_n = 0;
    for (int k = 0; k < 3; k++) pend[k] = 0;
    @(posedge clk); #1 rst_n = 1;
    #5;
    chk(reg_rdata == 0, "R1", reg_rdata, 0);
    idle(4);
    scan(1, '1, 16, -1, 0);
    chk(dout[15:0] == 16'hF111, "R1", dout[15:0], 16'hF111);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule